// File: doc/BRIEF.md
# Serial Command Transmit Controller

This block is the device side of a three-wire control port (enable, serial clock, data) on a radio transmitter. The host raises enable and clocks in a two-bit command, least significant bit first. If the command selects transmit, the host then clocks in a six-bit transmitter setup word, most significant bit first. An extra clock edge arms the transmitter. The next edge carries the first payload bit and switches on the power amplifier. From then on the payload flows over the data line with no clock at all, and a device-generated baud clock is offered to the host for as long as enable stays high.

Every pin is brought into the system clock domain by a short synchronizer. An edge detector picks the sampling edge of the serial clock, and a parameter sets its polarity. A power-down input forces the protective bits: transmit is locked and the set-power-down bit is cleared. While the lock is set, a transmit command is decoded but has no effect. A separate unlock input clears the lock. The most significant setup bit asks for the baud divider to restart at the first payload bit, so that the baud clock lines up with the data.

Top module: `serial_tx_ctrl`

## Requirements
- R1: After reset, lockTx, setPd, txActive, paOn, baudOe, baudClk, txData and txConfig are all 0.
- R2: Command bits are sampled C0 first, then C1. Only C1C0 = 11 is a transmit command. Any other code is ignored until enable drops: no setup word is captured, and txActive and paOn stay 0.
- R3: After a transmit command, six setup bits are sampled with bit 5 first. txConfig takes the complete word at the sixth sampling edge and keeps it until the next complete word.
- R4: The first sampling edge after the sixth setup bit sets txActive and baudOe. paOn stays 0.
- R5: The next sampling edge sets paOn, and txData takes the data line value from that edge. paOn is never 1 unless txActive is 1.
- R6: While paOn is 1, txData follows the data line with no serial clock edges.
- R7: While baudOe is 1, baudClk is a square wave with half period BAUD_DIV system clocks. While baudOe is 0, baudClk is 0.
- R8: When txConfig bit 5 is 1, the baud divider restarts at the first payload edge. baudClk is 0 there and first rises BAUD_DIV system clocks later.
- R9: Enable low returns the controller to idle within three system clocks. It clears txActive, paOn, baudOe and txData, and discards partial command or setup bits.
- R10: pdSetReq sets setPd. A pwrDown cycle sets lockTx to 1, clears setPd to 0 and aborts any transmit.
- R11: While lockTx is 1, a transmit command is decoded but ignored: txActive and paOn stay 0 and txConfig is unchanged. An unlockTx cycle clears lockTx.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| serEn | input | 1 | Serial port enable from the host |
| serClk | input | 1 | Serial clock from the host |
| serData | input | 1 | Serial data line (command, setup, payload) |
| pwrDown | input | 1 | Power-down entry strobe |
| unlockTx | input | 1 | Clears the transmit lock |
| pdSetReq | input | 1 | Sets the set-power-down bit |
| txActive | output | 1 | Controller is in a transmit state |
| paOn | output | 1 | Power-amplifier enable |
| baudClk | output | 1 | Device-generated baud clock |
| baudOe | output | 1 | Output enable for baudClk toward the host |
| txConfig | output | 6 | Last complete setup word |
| txData | output | 1 | Current transmit data bit |
| lockTx | output | 1 | Transmit lock bit |
| setPd | output | 1 | Set-power-down bit |

## Verification
A pin edge reaches the state and the outputs on the third system clock edge after it: two synchronizer stages, then one register. The direct system-domain strobes pwrDown, unlockTx and pdSetReq show up on the first edge. The bench keeps ten system clocks between serial edges and checks levels at least five clocks after the last pin change, so every result is already settled when it is sampled. Baud timing is the one exact check. The bench counts clocks from the first cycle where paOn reads 1 to the first rise of baudClk (exactly BAUD_DIV), and between two rises (exactly 2*BAUD_DIV).

// File: rtl/stx_pkg.sv
package stx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_CFG,
    ST_ARM,
    ST_WAIT,
    ST_RUN,
    ST_IGNORE
  } stxState_e;

  typedef struct packed {
    logic clearAll;
    logic shiftCmd;
    logic shiftCfg;
    logic loadCfg;
    logic armTx;
    logic startTx;
    logic stream;
  } stxStrobe_t;

endpackage

// File: rtl/stx_pin_sync.sv
module stx_pin_sync #(
  parameter int SYNC_STAGES   = 2,
  parameter bit SAMPLE_RISING = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic enIn,
  input  logic sclkIn,
  input  logic dataIn,
  output logic enSync,
  output logic dataSync,
  output logic sampleEdge
);

  logic [SYNC_STAGES-1:0] enPipe;
  logic [SYNC_STAGES-1:0] dPipe;
  logic [SYNC_STAGES:0]   cPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enPipe <= '0;
      dPipe  <= '0;
      cPipe  <= '0;
    end else begin
      enPipe <= {enPipe[SYNC_STAGES-2:0], enIn};
      dPipe  <= {dPipe[SYNC_STAGES-2:0], dataIn};
      cPipe  <= {cPipe[SYNC_STAGES-1:0], sclkIn};
    end
  end

  assign enSync   = enPipe[SYNC_STAGES-1];
  assign dataSync = dPipe[SYNC_STAGES-1];

  generate
    if (SAMPLE_RISING) begin : g_rise
      assign sampleEdge = cPipe[SYNC_STAGES-1] & ~cPipe[SYNC_STAGES];
    end else begin : g_fall
      assign sampleEdge = ~cPipe[SYNC_STAGES-1] & cPipe[SYNC_STAGES];
    end
  endgenerate

endmodule

// File: rtl/stx_control.sv
module stx_control
  import stx_pkg::*;
#(
  parameter int                  CMD_BITS = 2,
  parameter int                  CFG_BITS = 6,
  parameter logic [CMD_BITS-1:0] TX_CODE  = '1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enSync,
  input  logic                dataSync,
  input  logic                sampleEdge,
  input  logic                pwrDown,
  input  logic                lockTx,
  input  logic [CMD_BITS-1:0] cmdReg,
  output stxStrobe_t          strobe,
  output logic                txActive
);

  localparam int MAX_BITS = (CFG_BITS > CMD_BITS) ? CFG_BITS : CMD_BITS;
  localparam int CNT_W    = (MAX_BITS > 2) ? $clog2(MAX_BITS) : 1;
  localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(CMD_BITS - 1);
  localparam logic [CNT_W-1:0] CFG_LAST = CNT_W'(CFG_BITS - 1);

  stxState_e        state, stateNxt;
  logic [CNT_W-1:0] bitCnt, cntNxt;
  logic [CMD_BITS-1:0] cmdWord;

  // cmdWord[0] is C0, the first bit received
  assign cmdWord = {dataSync, cmdReg[CMD_BITS-1:1]};

  always_comb begin
    stateNxt = state;
    cntNxt   = bitCnt;
    strobe   = '0;
    if (pwrDown || !enSync) begin
      stateNxt        = ST_IDLE;
      cntNxt          = '0;
      strobe.clearAll = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          stateNxt = ST_CMD;
          cntNxt   = '0;
        end
        ST_CMD: if (sampleEdge) begin
          strobe.shiftCmd = 1'b1;
          if (bitCnt == CMD_LAST) begin
            cntNxt   = '0;
            stateNxt = (cmdWord == TX_CODE && !lockTx) ? ST_CFG : ST_IGNORE;
          end else begin
            cntNxt = bitCnt + 1'b1;
          end
        end
        ST_CFG: if (sampleEdge) begin
          strobe.shiftCfg = 1'b1;
          if (bitCnt == CFG_LAST) begin
            strobe.loadCfg = 1'b1;
            cntNxt         = '0;
            stateNxt       = ST_ARM;
          end else begin
            cntNxt = bitCnt + 1'b1;
          end
        end
        ST_ARM: if (sampleEdge) begin
          strobe.armTx = 1'b1;
          stateNxt     = ST_WAIT;
        end
        ST_WAIT: if (sampleEdge) begin
          strobe.startTx = 1'b1;
          strobe.stream  = 1'b1;
          stateNxt       = ST_RUN;
        end
        ST_RUN:    strobe.stream = 1'b1;
        ST_IGNORE: ;
        default:   stateNxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      state  <= stateNxt;
      bitCnt <= cntNxt;
    end
  end

  assign txActive = (state == ST_WAIT) || (state == ST_RUN);

  // R9
  idle_on_disable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enSync |=> state == ST_IDLE);

  // R11
  lock_blocks_tx_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lockTx && !txActive) |=> !txActive);

  // R4
  arm_before_tx_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txActive) |-> $past(state == ST_ARM));

endmodule

// File: rtl/stx_datapath.sv
module stx_datapath
  import stx_pkg::*;
#(
  parameter int CMD_BITS = 2,
  parameter int CFG_BITS = 6,
  parameter int BAUD_DIV = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  stxStrobe_t          strobe,
  input  logic                dataSync,
  input  logic                pwrDown,
  input  logic                unlockTx,
  input  logic                pdSetReq,
  output logic [CMD_BITS-1:0] cmdReg,
  output logic [CFG_BITS-1:0] txConfig,
  output logic                txData,
  output logic                paOn,
  output logic                baudOe,
  output logic                baudClk,
  output logic                lockTx,
  output logic                setPd
);

  localparam int BW = $clog2(BAUD_DIV + 1);
  localparam logic [BW-1:0] BAUD_LAST = BW'(BAUD_DIV - 1);

  logic [CFG_BITS-2:0] cfgShift;
  logic [BW-1:0]       baudCnt;
  logic                baudRestart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg   <= '0;
      cfgShift <= '0;
      txConfig <= '0;
      txData   <= 1'b0;
      paOn     <= 1'b0;
      baudOe   <= 1'b0;
    end else if (strobe.clearAll) begin
      cmdReg   <= '0;
      cfgShift <= '0;
      txData   <= 1'b0;
      paOn     <= 1'b0;
      baudOe   <= 1'b0;
    end else begin
      if (strobe.shiftCmd) cmdReg   <= {dataSync, cmdReg[CMD_BITS-1:1]};
      if (strobe.shiftCfg) cfgShift <= {cfgShift[CFG_BITS-3:0], dataSync};
      if (strobe.loadCfg)  txConfig <= {cfgShift, dataSync};
      if (strobe.armTx)    baudOe   <= 1'b1;
      if (strobe.startTx)  paOn     <= 1'b1;
      if (strobe.stream)   txData   <= dataSync;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockTx <= 1'b0;
      setPd  <= 1'b0;
    end else if (pwrDown) begin
      lockTx <= 1'b1;
      setPd  <= 1'b0;
    end else begin
      if (unlockTx) lockTx <= 1'b0;
      if (pdSetReq) setPd  <= 1'b1;
    end
  end

  assign baudRestart = strobe.clearAll || strobe.armTx ||
                       (strobe.startTx && txConfig[CFG_BITS-1]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baudCnt <= '0;
      baudClk <= 1'b0;
    end else if (baudRestart) begin
      baudCnt <= '0;
      baudClk <= 1'b0;
    end else if (baudOe) begin
      if (baudCnt == BAUD_LAST) begin
        baudCnt <= '0;
        baudClk <= ~baudClk;
      end else begin
        baudCnt <= baudCnt + 1'b1;
      end
    end
  end

  // R10
  pd_protect_chk: assert property (@(posedge clk) disable iff (!rstN)
    pwrDown |=> (lockTx && !setPd));

  // R11
  unlock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (unlockTx && !pwrDown) |=> !lockTx);

  // R7
  baud_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    baudCnt < BW'(BAUD_DIV));

  // R7
  baud_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !baudOe |-> !baudClk);

endmodule

// File: rtl/serial_tx_ctrl.sv
module serial_tx_ctrl
  import stx_pkg::*;
#(
  parameter int CMD_BITS      = 2,
  parameter int CFG_BITS      = 6,
  parameter int BAUD_DIV      = 4,
  parameter int SYNC_STAGES   = 2,
  parameter bit SAMPLE_RISING = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                serEn,
  input  logic                serClk,
  input  logic                serData,
  input  logic                pwrDown,
  input  logic                unlockTx,
  input  logic                pdSetReq,
  output logic                txActive,
  output logic                paOn,
  output logic                baudClk,
  output logic                baudOe,
  output logic [CFG_BITS-1:0] txConfig,
  output logic                txData,
  output logic                lockTx,
  output logic                setPd
);

  logic                enSync, dataSync, sampleEdge;
  logic [CMD_BITS-1:0] cmdReg;
  stxStrobe_t          strobe;

  stx_pin_sync #(
    .SYNC_STAGES  (SYNC_STAGES),
    .SAMPLE_RISING(SAMPLE_RISING)
  ) i_sync (
    .clk       (clk),
    .rstN      (rstN),
    .enIn      (serEn),
    .sclkIn    (serClk),
    .dataIn    (serData),
    .enSync    (enSync),
    .dataSync  (dataSync),
    .sampleEdge(sampleEdge)
  );

  stx_control #(
    .CMD_BITS(CMD_BITS),
    .CFG_BITS(CFG_BITS)
  ) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .enSync    (enSync),
    .dataSync  (dataSync),
    .sampleEdge(sampleEdge),
    .pwrDown   (pwrDown),
    .lockTx    (lockTx),
    .cmdReg    (cmdReg),
    .strobe    (strobe),
    .txActive  (txActive)
  );

  stx_datapath #(
    .CMD_BITS(CMD_BITS),
    .CFG_BITS(CFG_BITS),
    .BAUD_DIV(BAUD_DIV)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .dataSync(dataSync),
    .pwrDown (pwrDown),
    .unlockTx(unlockTx),
    .pdSetReq(pdSetReq),
    .cmdReg  (cmdReg),
    .txConfig(txConfig),
    .txData  (txData),
    .paOn    (paOn),
    .baudOe  (baudOe),
    .baudClk (baudClk),
    .lockTx  (lockTx),
    .setPd   (setPd)
  );

  // R5
  pa_needs_tx_chk: assert property (@(posedge clk) disable iff (!rstN)
    paOn |-> txActive);

  // R5
  pa_after_arm_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(paOn) |-> $past(txActive));

endmodule

// File: tb/test_serial_tx_ctrl.sv
module test_serial_tx_ctrl;

  localparam int BAUD_DIV = 4;
  localparam int HALF     = 10;

  localparam logic [12:0] M_LOCK = 13'h1000;
  localparam logic [12:0] M_SPD  = 13'h0800;
  localparam logic [12:0] M_ACT  = 13'h0400;
  localparam logic [12:0] M_PA   = 13'h0200;
  localparam logic [12:0] M_OE   = 13'h0100;
  localparam logic [12:0] M_BCK  = 13'h0080;
  localparam logic [12:0] M_DAT  = 13'h0040;
  localparam logic [12:0] M_CFG  = 13'h003F;
  localparam logic [12:0] M_CTL  = M_ACT | M_PA | M_OE;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serEn = 1'b0, serClk = 1'b0, serData = 1'b0;
  logic pwrDown = 1'b0, unlockTx = 1'b0, pdSetReq = 1'b0;
  logic txActive, paOn, baudClk, baudOe, txData, lockTx, setPd;
  logic [5:0] txConfig;
  logic [12:0] obs;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  string       qReq[$];
  bit          qMeas[$];
  logic [12:0] qExp[$];
  logic [12:0] qMask[$];
  int          qGot[$];
  int          qN[$];

  always #10 clk = ~clk;

  serial_tx_ctrl #(.BAUD_DIV(BAUD_DIV)) i_serial_tx_ctrl (
    .clk(clk), .rstN(rstN), .serEn(serEn), .serClk(serClk), .serData(serData),
    .pwrDown(pwrDown), .unlockTx(unlockTx), .pdSetReq(pdSetReq),
    .txActive(txActive), .paOn(paOn), .baudClk(baudClk), .baudOe(baudOe),
    .txConfig(txConfig), .txData(txData), .lockTx(lockTx), .setPd(setPd)
  );

  assign obs = {lockTx, setPd, txActive, paOn, baudOe, baudClk, txData, txConfig};

  // monitor: pops one expected item per falling edge and compares
  always @(negedge clk) begin
    if (qReq.size() > 0) begin
      string r; bit m; logic [12:0] e, k; int g, n;
      r = qReq.pop_front(); m = qMeas.pop_front(); e = qExp.pop_front();
      k = qMask.pop_front(); g = qGot.pop_front(); n = qN.pop_front();
      total++;
      if (m) begin
        if (g != n) begin
          bad++;
          $display("FAIL %s: got %0d expected %0d", r, g, n);
        end
      end else if (((obs ^ e) & k) != 0) begin
        bad++;
        $display("FAIL %s: got %013b expected %013b mask %013b", r, obs, e, k);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expectOut(string r, logic [12:0] e, logic [12:0] k);
    qReq.push_back(r); qMeas.push_back(1'b0); qExp.push_back(e);
    qMask.push_back(k); qGot.push_back(0); qN.push_back(0);
    tick(2);
  endtask

  task automatic expectNum(string r, int g, int n);
    qReq.push_back(r); qMeas.push_back(1'b1); qExp.push_back('0);
    qMask.push_back('0); qGot.push_back(g); qN.push_back(n);
    tick(2);
  endtask

  task automatic sendBit(logic b);
    serData = b; serClk = 1'b0; tick(HALF);
    serClk = 1'b1; tick(HALF);
  endtask

  // cmd is {C1,C0}; C0 goes first, setup word goes bit 5 first
  task automatic sendCmdCfg(logic [1:0] cmd, logic [5:0] cfg);
    sendBit(cmd[0]); sendBit(cmd[1]);
    for (int i = 5; i >= 0; i--) sendBit(cfg[i]);
  endtask

  task automatic enOn();  serEn = 1'b1; tick(4); endtask
  task automatic enOff(); serEn = 1'b0; tick(6); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    tick(5);
    rstN = 1'b1;
    tick(3);
    expectOut("R1 reset", 13'h0, 13'h1FFF);

    pdSetReq = 1'b1; tick(1); pdSetReq = 1'b0; tick(1);
    expectOut("R10 setPd request", M_SPD, M_SPD | M_LOCK);

    // non-transmit codes (C1C0 = 01, then 10)
    enOn(); sendCmdCfg(2'b01, 6'h3F); sendBit(1); sendBit(1);
    expectOut("R2 code 01 ignored", 13'h0, M_CTL | M_CFG);
    enOff();
    enOn(); sendCmdCfg(2'b10, 6'h3F); sendBit(1); sendBit(1);
    expectOut("R2 code 10 ignored", 13'h0, M_CTL | M_CFG);
    enOff();

    // partial bit discarded: stale C0=1 would make 1,1
    enOn(); sendBit(1); enOff();
    enOn(); sendBit(1); sendBit(0); for (int i = 0; i < 8; i++) sendBit(1);
    expectOut("R9 partial discarded", 13'h0, M_CTL | M_CFG);
    enOff();

    // main flow, bit 5 clear
    enOn(); sendCmdCfg(2'b11, 6'b010110);
    expectOut("R3 setup captured", 13'h016, M_CTL | M_CFG);
    sendBit(0);
    expectOut("R4 armed", M_ACT | M_OE, M_CTL);
    sendBit(1);
    expectOut("R5 pa on first bit", M_ACT | M_OE | M_PA | M_DAT, M_CTL | M_DAT);
    n = 0;
    for (int k = 0; k < 100 && baudClk; k++) tick(1);
    for (int k = 0; k < 100 && !baudClk; k++) tick(1);
    for (int k = 0; k < 100 && baudClk; k++) begin tick(1); n++; end
    for (int k = 0; k < 100 && !baudClk; k++) begin tick(1); n++; end
    expectNum("R7 baud period", n, 2 * BAUD_DIV);
    serData = 1'b0; tick(5);
    expectOut("R6 stream 0", M_PA, M_PA | M_DAT);
    serData = 1'b1; tick(5);
    expectOut("R6 stream 1", M_PA | M_DAT, M_PA | M_DAT);
    enOff();
    expectOut("R9 disable clears", 13'h016, M_CTL | M_BCK | M_DAT | M_CFG);

    // bit 5 set: divider restarts at first payload edge
    enOn(); sendCmdCfg(2'b11, 6'b100111);
    sendBit(1);
    expectOut("R4 armed a5", M_ACT | M_OE | 13'h027, M_CTL | M_CFG);
    serData = 1'b0; serClk = 1'b0; tick(HALF);
    serClk = 1'b1;
    for (int k = 0; k < 40 && !paOn; k++) tick(1);
    n = 0;
    for (int k = 0; k < 100 && !baudClk; k++) begin tick(1); n++; end
    expectNum("R8 baud restart", n, BAUD_DIV);
    tick(HALF);
    expectOut("R5 first bit 0", M_ACT | M_PA, M_CTL & ~M_OE | M_DAT);
    pwrDown = 1'b1; tick(1); pwrDown = 1'b0; tick(1);
    expectOut("R10 power down", M_LOCK, M_LOCK | M_SPD | M_CTL);
    enOff();

    // locked transmit ignored
    enOn(); sendCmdCfg(2'b11, 6'b000001); sendBit(1); sendBit(1);
    expectOut("R11 locked ignored", M_LOCK | 13'h027, M_LOCK | M_CTL | M_CFG);
    enOff();
    unlockTx = 1'b1; tick(1); unlockTx = 1'b0; tick(1);
    expectOut("R11 unlocked", 13'h0, M_LOCK);
    enOn(); sendCmdCfg(2'b11, 6'b000001); sendBit(0);
    expectOut("R11 tx after unlock", M_ACT | M_OE | 13'h001, M_CTL | M_CFG);
    sendBit(1);
    expectOut("R5 pa after unlock", M_ACT | M_OE | M_PA | M_DAT, M_CTL | M_DAT);
    enOff();

    tick(4);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule